// File: doc/BRIEF.md
# Mixed-Rule Control Register Bank

This block is a bank of 32-bit control and status registers behind one write port and one read port, in which every listed address applies its own rule to incoming data. Interrupt status bits are cleared by writing ones. The interrupt mask is toggled by XOR. A pair of general registers are set-only and clear-only. One register reacts to a single bit, and another returns to zero on any write. A memory-command register can never hold its busy bit. A group of registers serves a graphics interface unit: a control register that emits a reset pulse and drives a pause flag, a mode register, and a status register that mirrors two mode bits.

Hardware event lines set interrupt status bits, and a registered interrupt request reports any status bit that is also enabled in the mask. All other addresses in the word-address space behave as plain storage. Reads have one cycle of latency. A read issued in the same cycle as a write to the same address returns the value held before that write.

Top module: `ctl_reg_bank`

## Requirements
- R1: After reset, the interrupt status, interrupt mask, set-only register, bit-8 register, graphics control, mode and status registers read 0, the clear-only register reads 0xFFFFFFFF, the zero-on-write register reads 0x000000FF, and irq, gfx_rst_pulse, gfx_pause and rd_data are 0.
- R2: A write to the interrupt status register (word address 0) clears each of its 16 bits whose matching data bit is 1 and leaves the others unchanged; bits 31:16 always read 0.
- R3: An evt_set bit that is 1 in the same cycle as a write to the interrupt status register sets that status bit, and this overrides a clear of the same bit.
- R4: A write to the interrupt mask register (word address 1) replaces the mask with the mask XOR data bits 15:0; data bits 31:16 have no effect.
- R5: irq is 1 exactly one cycle after any bit is 1 in both the interrupt status and the mask, and 0 one cycle after no such bit exists.
- R6: A write to word address 2 ORs the data into that register.
- R7: A write to word address 3 clears that register's bits wherever the data is 1.
- R8: A write to word address 4 sets bit 8 of that register to data bit 8; every other bit stays 0.
- R9: Any write to word address 5 makes that register 0, whatever the data.
- R10: A write to the graphics control register (word address 6) stores only data bit 3, drives gfx_pause to data bit 3 from the next cycle on, and when data bit 0 is 1 raises gfx_rst_pulse for exactly one cycle.
- R11: A write to the graphics mode register (word address 7) stores the data and copies data bits 0 and 2 into bits 0 and 2 of the graphics status register (word address 8), leaving its other bits unchanged; the status register is otherwise written as plain storage.
- R12: A write to the memory-command register (word address 9) stores the data with bit 31 forced to 0.
- R13: Word addresses 10 to 15 store the written data unchanged; rd_data shows the value of rd_addr in the cycle after rd_en is 1 and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Word address of the read |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| evt_set | input | 16 | Hardware events, each sets one interrupt status bit |
| irq | output | 1 | Registered interrupt request |
| gfx_rst_pulse | output | 1 | One-cycle reset pulse for the graphics interface |
| gfx_pause | output | 1 | Pause flag for the graphics interface |

## Verification
The assertions assume that only one write strobe reaches the bank per cycle and that the address is stable while the strobe is high, so each register rule sees exactly one write. They also assume that reset is high from time zero. The stimulus drives every input on the falling edge, holds evt_set at zero except in the cycles meant to test event priority, and always pulses wr_en and rd_en for a single cycle at a time.

// File: rtl/ctl_reg_pkg.sv
package ctl_reg_pkg;

  // word addresses whose behaviour differs from plain storage
  localparam int unsigned A_IRQ_STAT = 0;
  localparam int unsigned A_IRQ_MASK = 1;
  localparam int unsigned A_GFX_CTL  = 6;
  localparam int unsigned A_GFX_MODE = 7;
  localparam int unsigned A_GFX_STAT = 8;

  // single-rule registers
  localparam int unsigned NUM_RULE = 5;

  typedef enum logic [2:0] {
    RULE_SET,     // OR data in
    RULE_CLR,     // AND with inverted data
    RULE_BIT8,    // only bit 8 follows data
    RULE_WZERO,   // any write clears
    RULE_NOBUSY   // store, top bit forced low
  } rule_e;

  // graphics control bit positions
  localparam int unsigned GCTL_RST_BIT   = 0;
  localparam int unsigned GCTL_PAUSE_BIT = 3;
  localparam int unsigned SEL_BIT        = 8;

  function automatic rule_e rule_of(input int unsigned idx);
    case (idx)
      0:       return RULE_SET;
      1:       return RULE_CLR;
      2:       return RULE_BIT8;
      3:       return RULE_WZERO;
      default: return RULE_NOBUSY;
    endcase
  endfunction

  function automatic int unsigned rule_addr(input int unsigned idx);
    if (idx < 4) return 2 + idx;
    return 9;
  endfunction

endpackage

// File: rtl/ctl_rule_reg.sv
module ctl_rule_reg
  import ctl_reg_pkg::*;
#(
  parameter int unsigned       DATA_W  = 32,
  parameter rule_e             KIND    = RULE_SET,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  localparam logic [DATA_W-1:0] BIT8_MASK = DATA_W'(1) << SEL_BIT;

  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = q;
    case (KIND)
      RULE_SET:    nxt = q | wdata;
      RULE_CLR:    nxt = q & ~wdata;
      RULE_BIT8:   nxt = (q & ~BIT8_MASK) | (wdata & BIT8_MASK);
      RULE_WZERO:  nxt = '0;
      default: begin
        nxt = wdata;
        nxt[DATA_W-1] = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (we) q <= nxt;
  end

  generate
    if (KIND == RULE_WZERO) begin : g_chk_zero
      a_r9_zero_after_write: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == '0));
    end
    if (KIND == RULE_NOBUSY) begin : g_chk_busy
      a_r12_busy_low: assert property (@(posedge clk) disable iff (rst)
        we |=> !q[DATA_W-1]);
    end
    if (KIND == RULE_BIT8) begin : g_chk_bit8
      a_r8_other_bits_kept: assert property (@(posedge clk) disable iff (rst)
        we |=> ((q & ~BIT8_MASK) == $past(q & ~BIT8_MASK)));
    end
  endgenerate

endmodule

// File: rtl/ctl_irq_unit.sv
module ctl_irq_unit #(
  parameter int unsigned IRQ_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             st_we,
  input  logic             mk_we,
  input  logic [IRQ_W-1:0] wlow,
  input  logic [IRQ_W-1:0] evt,
  output logic [IRQ_W-1:0] stat_q,
  output logic [IRQ_W-1:0] mask_q,
  output logic             irq
);

  logic [IRQ_W-1:0] clr_bits;

  assign clr_bits = st_we ? wlow : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      // events win over a same-cycle clear
      stat_q <= (stat_q & ~clr_bits) | evt;
      if (mk_we) mask_q <= mask_q ^ wlow;
      irq <= |(stat_q & mask_q);
    end
  end

  a_r2_w1c: assert property (@(posedge clk) disable iff (rst)
    (st_we && evt == '0) |=> (stat_q == $past(stat_q & ~wlow)));

  a_r3_evt_wins: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));

  a_r4_mask_xor: assert property (@(posedge clk) disable iff (rst)
    mk_we |=> (mask_q == $past(mask_q ^ wlow)));

  a_r4_mask_hold: assert property (@(posedge clk) disable iff (rst)
    !mk_we |=> $stable(mask_q));

endmodule

// File: rtl/ctl_gfx_unit.sv
module ctl_gfx_unit
  import ctl_reg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic              mode_we,
  input  logic              stat_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctl_q,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] gstat_q,
  output logic              rst_pulse,
  output logic              pause
);

  localparam logic [DATA_W-1:0] CTL_KEEP = DATA_W'(1) << GCTL_PAUSE_BIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      mode_q    <= '0;
      gstat_q   <= '0;
      rst_pulse <= 1'b0;
      pause     <= 1'b0;
    end else begin
      rst_pulse <= ctl_we & wdata[GCTL_RST_BIT];
      if (ctl_we) begin
        ctl_q <= wdata & CTL_KEEP;
        pause <= wdata[GCTL_PAUSE_BIT];
      end
      if (mode_we) begin
        mode_q     <= wdata;
        gstat_q[0] <= wdata[0];
        gstat_q[2] <= wdata[2];
      end else if (stat_we) begin
        gstat_q <= wdata;
      end
    end
  end

  a_r10_pulse_once: assert property (@(posedge clk) disable iff (rst)
    rst_pulse |=> !rst_pulse);

  a_r10_pause_matches_ctl: assert property (@(posedge clk) disable iff (rst)
    pause == ctl_q[GCTL_PAUSE_BIT]);

  a_r11_mirror: assert property (@(posedge clk) disable iff (rst)
    mode_we |=> (gstat_q[0] == mode_q[0] && gstat_q[2] == mode_q[2]));

endmodule

// File: rtl/ctl_plain_store.sv
module ctl_plain_store #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_reg_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 4,
  parameter int unsigned       DATA_W   = 32,
  parameter int unsigned       IRQ_W    = 16,
  parameter logic [DATA_W-1:0] CLR_RST  = '1,
  parameter logic [DATA_W-1:0] ZERO_RST = 'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [IRQ_W-1:0]  evt_set,
  output logic              irq,
  output logic              gfx_rst_pulse,
  output logic              gfx_pause
);

  logic [IRQ_W-1:0]  stat_q, mask_q;
  logic [DATA_W-1:0] gctl_q, gmode_q, gstat_q;
  logic [DATA_W-1:0] rule_q [NUM_RULE];
  logic [DATA_W-1:0] store_rd;
  logic [DATA_W-1:0] spec_val, spec_q;
  logic              spec_hit, spec_sel_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned idx);
    return a == ADDR_W'(idx);
  endfunction

  ctl_irq_unit #(.IRQ_W(IRQ_W)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .st_we  (wr_en && hit(wr_addr, A_IRQ_STAT)),
    .mk_we  (wr_en && hit(wr_addr, A_IRQ_MASK)),
    .wlow   (wr_data[IRQ_W-1:0]),
    .evt    (evt_set),
    .stat_q (stat_q),
    .mask_q (mask_q),
    .irq    (irq)
  );

  ctl_gfx_unit #(.DATA_W(DATA_W)) u_gfx (
    .clk       (clk),
    .rst       (rst),
    .ctl_we    (wr_en && hit(wr_addr, A_GFX_CTL)),
    .mode_we   (wr_en && hit(wr_addr, A_GFX_MODE)),
    .stat_we   (wr_en && hit(wr_addr, A_GFX_STAT)),
    .wdata     (wr_data),
    .ctl_q     (gctl_q),
    .mode_q    (gmode_q),
    .gstat_q   (gstat_q),
    .rst_pulse (gfx_rst_pulse),
    .pause     (gfx_pause)
  );

  generate
    for (genvar i = 0; i < NUM_RULE; i++) begin : g_rule
      localparam rule_e KIND = rule_of(i);
      localparam logic [DATA_W-1:0] RV =
        (KIND == RULE_CLR)   ? CLR_RST  :
        (KIND == RULE_WZERO) ? ZERO_RST : '0;
      ctl_rule_reg #(.DATA_W(DATA_W), .KIND(KIND), .RST_VAL(RV)) u_reg (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en && hit(wr_addr, rule_addr(i))),
        .wdata (wr_data),
        .q     (rule_q[i])
      );
    end
  endgenerate

  // every write lands in the store; listed addresses are read from their own logic
  ctl_plain_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (store_rd)
  );

  always_comb begin
    spec_val = '0;
    spec_hit = 1'b1;
    if      (hit(rd_addr, A_IRQ_STAT)) spec_val = DATA_W'(stat_q);
    else if (hit(rd_addr, A_IRQ_MASK)) spec_val = DATA_W'(mask_q);
    else if (hit(rd_addr, A_GFX_CTL))  spec_val = gctl_q;
    else if (hit(rd_addr, A_GFX_MODE)) spec_val = gmode_q;
    else if (hit(rd_addr, A_GFX_STAT)) spec_val = gstat_q;
    else                               spec_hit = 1'b0;
    for (int i = 0; i < NUM_RULE; i++) begin
      if (hit(rd_addr, rule_addr(i))) begin
        spec_val = rule_q[i];
        spec_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spec_q     <= '0;
      spec_sel_q <= 1'b0;
    end else if (rd_en) begin
      spec_q     <= spec_val;
      spec_sel_q <= spec_hit;
    end
  end

  assign rd_data = spec_sel_q ? spec_q : store_rd;

  a_r13_read_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

endmodule

// File: tb/sim_ctl_reg_bank.sv
`timescale 1ns/1ps
module sim_ctl_reg_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] evt_set = '0;
  logic        irq, gfx_rst_pulse, gfx_pause;

  int checks = 0;
  int errors = 0;
  logic pend = 1'b0;
  logic done = 1'b0;

  typedef struct { logic [31:0] exp; string req; } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  ctl_reg_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .evt_set(evt_set),
    .irq(irq), .gfx_rst_pulse(gfx_rst_pulse), .gfx_pause(gfx_pause)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [15:0] e = '0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; evt_set = e;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; evt_set = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    item_t it;
    it.exp = exp; it.req = req;
    sb.push_back(it);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: compares each completed read against the scoreboard
  always @(posedge clk) pend <= rd_en;
  always @(negedge clk) begin
    if (pend) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R13 actual %h expected none (unexpected read)", rd_data);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(rd_data, it.exp, it.req);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk({31'b0, irq}, 0, "R1 irq");
    chk({31'b0, gfx_rst_pulse}, 0, "R1 pulse");
    chk({31'b0, gfx_pause}, 0, "R1 pause");
    chk(rd_data, 0, "R1 rd_data");
    rd(4'd0, 32'h0, "R1 stat");
    rd(4'd1, 32'h0, "R1 mask");
    rd(4'd3, 32'hFFFF_FFFF, "R1 clear-only");
    rd(4'd5, 32'h0000_00FF, "R1 zero-on-write");
    rd(4'd6, 32'h0, "R1 gfx ctl");

    // R4 mask toggle, upper half ignored
    wr(4'd1, 32'hFFFF_00A5);
    rd(4'd1, 32'h0000_00A5, "R4 xor first");
    wr(4'd1, 32'h0000_0005);
    rd(4'd1, 32'h0000_00A0, "R4 xor second");

    // R5 irq latency from an event
    @(negedge clk) evt_set = 16'h0021;
    @(posedge clk);
    @(negedge clk) evt_set = '0;
    chk({31'b0, irq}, 0, "R5 irq not yet");
    @(negedge clk);
    chk({31'b0, irq}, 1, "R5 irq raised");
    rd(4'd0, 32'h0000_0021, "R3 event set status");

    // R2 write-one-to-clear
    wr(4'd0, 32'h0000_0001);
    rd(4'd0, 32'h0000_0020, "R2 w1c");
    // R3 set beats clear
    wr(4'd0, 32'h0000_0020, 16'h0020);
    rd(4'd0, 32'h0000_0020, "R3 set priority");
    wr(4'd0, 32'hFFFF_FFFF);
    chk({31'b0, irq}, 1, "R5 irq lags clear");
    @(negedge clk);
    chk({31'b0, irq}, 0, "R5 irq dropped");
    rd(4'd0, 32'h0, "R2 clear all");

    // R6 set-only
    wr(4'd2, 32'h0000_00F0);
    wr(4'd2, 32'h0000_0300);
    rd(4'd2, 32'h0000_03F0, "R6 or");
    // R7 clear-only
    wr(4'd3, 32'h0000_FF00);
    rd(4'd3, 32'hFFFF_00FF, "R7 andn");
    // R8 bit 8 only
    wr(4'd4, 32'hFFFF_FFFF);
    rd(4'd4, 32'h0000_0100, "R8 set bit8");
    wr(4'd4, 32'h0000_FEFF);
    rd(4'd4, 32'h0, "R8 clear bit8");
    // R9 zero on write
    wr(4'd5, 32'hFFFF_FFFF);
    rd(4'd5, 32'h0, "R9 zeroed");

    // R10 graphics control
    wr(4'd6, 32'h0000_0009);
    chk({31'b0, gfx_rst_pulse}, 1, "R10 pulse high");
    chk({31'b0, gfx_pause}, 1, "R10 pause set");
    @(negedge clk);
    chk({31'b0, gfx_rst_pulse}, 0, "R10 pulse one cycle");
    rd(4'd6, 32'h0000_0008, "R10 stores bit3");
    wr(4'd6, 32'h0000_0001);
    chk({31'b0, gfx_rst_pulse}, 1, "R10 pulse again");
    chk({31'b0, gfx_pause}, 0, "R10 pause cleared");
    wr(4'd6, 32'hFFFF_FFF6);
    chk({31'b0, gfx_rst_pulse}, 0, "R10 no pulse");
    rd(4'd6, 32'h0, "R10 bit3 low");

    // R11 mode mirror
    wr(4'd8, 32'h0000_00F0);
    wr(4'd7, 32'h0000_0005);
    rd(4'd8, 32'h0000_00F5, "R11 mirror set");
    rd(4'd7, 32'h0000_0005, "R11 mode stored");
    wr(4'd7, 32'h0000_0002);
    rd(4'd8, 32'h0000_00F0, "R11 mirror clear");

    // R12 busy bit
    wr(4'd9, 32'hFFFF_FFFF);
    rd(4'd9, 32'h7FFF_FFFF, "R12 busy low");

    // R13 plain storage
    wr(4'd12, 32'hDEAD_BEEF);
    wr(4'd15, 32'h1234_5678);
    rd(4'd12, 32'hDEAD_BEEF, "R13 plain a");
    rd(4'd15, 32'h1234_5678, "R13 plain b");
    @(negedge clk);
    chk(rd_data, 32'h1234_5678, "R13 hold");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule